// File: doc/BRIEF.md
# Streaming Video Control Packet Snooper

The block listens to a streaming video link between a source and a sink and pulls the frame geometry out of every control packet that passes. It only watches the link (valid, ready, start and end of packet, data) and never drives any of it, so it can be hung on any point of an existing video path to report the resolution that is actually being sent.

A beat counts only on a cycle where the source offers data and the sink accepts it. The payload is read as 4-bit nibbles from the low bits of each such beat, so a control packet that the sink breaks into pieces with backpressure decodes to the same width, height and interlace value as one sent in a single burst. New values appear together with a one-cycle strobe. A control packet that ends early raises a one-cycle error and leaves the last good values in place.

Top module: `vsnoop_ctrl_decoder`

## Requirements
- R1: A beat transfers only when valid_i and ready_i are both high in the same cycle; data_i, sop_i and eop_i on every other cycle have no effect on any output.
- R2: The beat that carries sop_i holds a packet type in data_i[3:0]: 0xF starts a control packet, while 0x0 (video) and any other value make the packet be skipped without changing width_o, height_o, interlace_o, upd_o or err_o.
- R3: The control payload is the next nine transferred beats, low 4 bits each, in this order: width bits 15:12, 11:8, 7:4, 3:0, then height bits 15:12, 11:8, 7:4, 3:0, then the 4-bit interlace value.
- R4: width_o, height_o and interlace_o change together only when all nine nibbles have arrived, with upd_o high for one cycle on the second clock edge after the edge on which the ninth nibble transfers; at all other times they hold.
- R5: A control packet split by any pattern of ready stalls or valid gaps, including ready high for a single cycle with no valid beat, decodes to exactly the same values as the same packet sent without gaps.
- R6: If eop_i transfers before the ninth nibble (including on the start beat of a control packet), the outputs keep their previous values and err_o is high for one cycle; err_o and upd_o are never high together.
- R7: Transferred beats after the ninth nibble are ignored up to eop_i, after which the block waits for a new start; a start beat seen in the middle of a packet restarts decoding from that beat.
- R8: While rst_ni is low the block is idle and width_o, height_o, interlace_o, upd_o and err_o are zero.
- R9: The registered transfer qualifier inside the block is low in every cycle that follows a cycle with no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Source valid on the link |
| ready_i | input | 1 | Sink ready on the link (zero latency) |
| sop_i | input | 1 | Start of packet on the link |
| eop_i | input | 1 | End of packet on the link |
| data_i | input | DATA_W | Link data; only bits 3:0 are decoded |
| width_o | output | DIM_W | Last decoded frame width |
| height_o | output | DIM_W | Last decoded frame height |
| interlace_o | output | 4 | Last decoded interlace nibble |
| upd_o | output | 1 | One-cycle strobe when the three values update |
| err_o | output | 1 | One-cycle strobe on a control packet that ends early |

## Verification
The hardest case to reach is a sink that raises ready for a single isolated cycle while the source has no beat to offer, right in the middle of a control payload, because it needs the two sides of the link to be out of step at the same moment. The bench gets there by driving ready as a one-in-eight pulse while the source inserts random valid gaps filled with junk data and stray start and end flags, so the pulses repeatedly fall on empty cycles between payload nibbles. Random ready gaps, a restart mid-packet, trailing beats and early ends cover the remaining paths of the capture state machine.

// File: rtl/vsnoop_pkg.sv
package vsnoop_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] PKT_CTRL = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CTRL,
    ST_SKIP
  } snoop_state_e;

endpackage

// File: rtl/vsnoop_beat_reg.sv
module vsnoop_beat_reg
  import vsnoop_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             beat_vld_o,
  output logic             beat_sop_o,
  output logic             beat_eop_o,
  output logic [NIB_W-1:0] beat_nib_o
);

  logic             xfer;
  logic             vld_q, sop_q, eop_q;
  logic [NIB_W-1:0] nib_q;

  assign xfer = valid_i & ready_i;

  // qualifier follows the handshake every cycle, so it never sticks high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      sop_q <= 1'b0;
      eop_q <= 1'b0;
      nib_q <= '0;
    end else begin
      vld_q <= xfer;
      if (xfer) begin
        sop_q <= sop_i;
        eop_q <= eop_i;
        nib_q <= nib_i;
      end
    end
  end

  assign beat_vld_o = vld_q;
  assign beat_sop_o = sop_q;
  assign beat_eop_o = eop_q;
  assign beat_nib_o = nib_q;

endmodule

// File: rtl/vsnoop_nib_acc.sv
module vsnoop_nib_acc
  import vsnoop_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   shift_i,
  input  logic [NIB_W-1:0]       nib_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [SLOTS*NIB_W-1:0] payload_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (shift_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // slot 0 is the first nibble and lands in the top of the payload
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [NIB_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q <= '0;
      else if (shift_i && cnt_q == CNT_W'(k))    slot_q <= nib_i;
    end
    assign payload_o[(SLOTS-1-k)*NIB_W +: NIB_W] = slot_q;
  end

endmodule

// File: rtl/vsnoop_ctrl_fsm.sv
module vsnoop_ctrl_fsm
  import vsnoop_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LAST_CNT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_vld_i,
  input  logic             beat_sop_i,
  input  logic             beat_eop_i,
  input  logic [NIB_W-1:0] beat_nib_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             shift_o,
  output logic             commit_o,
  output logic             short_o
);

  snoop_state_e state_q, state_d;
  logic         last_nib;

  assign last_nib = (cnt_i == CNT_W'(LAST_CNT));

  always_comb begin
    state_d  = state_q;
    clr_o    = 1'b0;
    shift_o  = 1'b0;
    commit_o = 1'b0;
    short_o  = 1'b0;
    // every move is gated by a completed transfer
    if (beat_vld_i) begin
      if (beat_sop_i) begin
        clr_o = 1'b1;
        if (beat_nib_i == PKT_CTRL) begin
          if (beat_eop_i) begin
            short_o = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_CTRL;
          end
        end else begin
          state_d = beat_eop_i ? ST_IDLE : ST_SKIP;
        end
      end else begin
        unique case (state_q)
          ST_CTRL: begin
            if (last_nib) begin
              commit_o = 1'b1;
              state_d  = beat_eop_i ? ST_IDLE : ST_SKIP;
            end else begin
              shift_o = 1'b1;
              if (beat_eop_i) begin
                short_o = 1'b1;
                state_d = ST_IDLE;
              end
            end
          end
          ST_SKIP: if (beat_eop_i) state_d = ST_IDLE;
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/vsnoop_ctrl_decoder.sv
module vsnoop_ctrl_decoder
  import vsnoop_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic [NIB_W-1:0]  interlace_o,
  output logic              upd_o,
  output logic              err_o
);

  localparam int NIB_PER_DIM = DIM_W / NIB_W;
  localparam int SLOTS       = 2 * NIB_PER_DIM;
  localparam int PAY_W       = SLOTS * NIB_W;
  localparam int CNT_W       = $clog2(SLOTS + 1);

  logic             beat_vld, beat_sop, beat_eop;
  logic [NIB_W-1:0] beat_nib;
  logic             clr, shift, commit, short_pkt;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] payload;

  if (DATA_W > NIB_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^data_i[DATA_W-1:NIB_W];
  end

  vsnoop_beat_reg u_beat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .ready_i    (ready_i),
    .sop_i      (sop_i),
    .eop_i      (eop_i),
    .nib_i      (data_i[NIB_W-1:0]),
    .beat_vld_o (beat_vld),
    .beat_sop_o (beat_sop),
    .beat_eop_o (beat_eop),
    .beat_nib_o (beat_nib)
  );

  vsnoop_nib_acc #(
    .SLOTS (SLOTS),
    .CNT_W (CNT_W)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .shift_i   (shift),
    .nib_i     (beat_nib),
    .cnt_o     (cnt),
    .payload_o (payload)
  );

  vsnoop_ctrl_fsm #(
    .CNT_W    (CNT_W),
    .LAST_CNT (SLOTS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_vld_i (beat_vld),
    .beat_sop_i (beat_sop),
    .beat_eop_i (beat_eop),
    .beat_nib_i (beat_nib),
    .cnt_i      (cnt),
    .clr_o      (clr),
    .shift_o    (shift),
    .commit_o   (commit),
    .short_o    (short_pkt)
  );

  logic [DIM_W-1:0] width_q, height_q;
  logic [NIB_W-1:0] il_q;
  logic             upd_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q  <= '0;
      height_q <= '0;
      il_q     <= '0;
      upd_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      upd_q <= commit;
      err_q <= short_pkt;
      if (commit) begin
        width_q  <= payload[PAY_W-1 -: DIM_W];
        height_q <= payload[DIM_W-1:0];
        il_q     <= beat_nib;
      end
    end
  end

  assign width_o     = width_q;
  assign height_o    = height_q;
  assign interlace_o = il_q;
  assign upd_o       = upd_q;
  assign err_o       = err_q;

endmodule

// File: rtl/vsnoop_ctrl_decoder_chk.sv
module vsnoop_ctrl_decoder_chk
  import vsnoop_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_i,
  input logic             eop_i,
  input logic [DIM_W-1:0] width_o,
  input logic [DIM_W-1:0] height_o,
  input logic [NIB_W-1:0] interlace_o,
  input logic             upd_o,
  input logic             err_o,
  input logic             beat_vld_i
);

  AST_QUAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_i) |=> !beat_vld_i); // R9

  AST_UPD_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(valid_i && ready_i, 2)); // R4

  AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o); // R4

  AST_OUTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable({width_o, height_o, interlace_o})); // R6

  AST_ERR_AFTER_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(valid_i && ready_i && eop_i, 2)); // R6

  AST_NO_UPD_WITH_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_o && err_o)); // R6

endmodule

bind vsnoop_ctrl_decoder vsnoop_ctrl_decoder_chk #(
  .DIM_W (DIM_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ready_i     (ready_i),
  .eop_i       (eop_i),
  .width_o     (width_o),
  .height_o    (height_o),
  .interlace_o (interlace_o),
  .upd_o       (upd_o),
  .err_o       (err_o),
  .beat_vld_i  (beat_vld)
);

// File: tb/vsnoop_ctrl_decoder_tb_top.sv
module vsnoop_ctrl_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 24;
  localparam int DIM_W      = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic              ready_i = 1'b0;
  logic              sop_i = 1'b0;
  logic              eop_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DIM_W-1:0]  width_o, height_o;
  logic [3:0]        interlace_o;
  logic              upd_o, err_o;

  int total = 0, bad = 0;
  int upd_seen = 0, err_seen = 0;
  int rdy_mode = 0, vgap_max = 0, phase = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsnoop_ctrl_decoder #(.DATA_W(DATA_W), .DIM_W(DIM_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_i(ready_i),
    .sop_i(sop_i), .eop_i(eop_i), .data_i(data_i), .width_o(width_o),
    .height_o(height_o), .interlace_o(interlace_o), .upd_o(upd_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (upd_o) upd_seen++;
      if (err_o) err_seen++;
    end
  end

  // sink ready: 0 always, 1 random, 2 one cycle in eight
  always @(negedge clk) begin
    phase = (phase + 1) % 8;
    case (rdy_mode)
      0:       ready_i = 1'b1;
      1:       ready_i = 1'($urandom_range(0, 1));
      default: ready_i = (phase == 0);
    endcase
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_beat(logic [3:0] nib, logic sop, logic eop);
    int g;
    g = (vgap_max > 0) ? $urandom_range(0, vgap_max) : 0;
    for (int i = 0; i < g; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      data_i  = DATA_W'($urandom);
      sop_i   = 1'($urandom_range(0, 1));
      eop_i   = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = {DATA_W'($urandom)} & ~DATA_W'(4'hF) | DATA_W'(nib);
    sop_i   = sop;
    eop_i   = eop;
    forever begin
      @(posedge clk);
      if (ready_i) break;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    valid_i = 1'b0;
    sop_i   = 1'b0;
    eop_i   = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_ctrl(logic [15:0] w, logic [15:0] h, logic [3:0] il, int extra);
    send_beat(4'hF, 1'b1, 1'b0);
    for (int i = 0; i < 9; i++) begin
      logic [3:0] n;
      if (i < 4)      n = w[15-4*i -: 4];
      else if (i < 8) n = h[15-4*(i-4) -: 4];
      else            n = il;
      send_beat(n, 1'b0, (i == 8) && (extra == 0));
    end
    for (int k = 0; k < extra; k++) send_beat(4'hF, 1'b0, k == extra - 1);
    settle();
  endtask

  task automatic send_partial(logic [3:0] ptype, int nnib, bit with_eop);
    send_beat(ptype, 1'b1, with_eop && nnib == 0);
    for (int i = 0; i < nnib; i++)
      send_beat(4'(i + 3), 1'b0, with_eop && i == nnib - 1);
  endtask

  task automatic chk_res(string req, int w, int h, int il, int du, int de, int u0, int e0);
    chk({req, " width"}, int'(width_o), w);
    chk({req, " height"}, int'(height_o), h);
    chk({req, " interlace"}, int'(interlace_o), il);
    chk({req, " updates"}, upd_seen - u0, du);
    chk({req, " errors"}, err_seen - e0, de);
  endtask

  task automatic t_reset();
    chk("R8 width", int'(width_o), 0);
    chk("R8 height", int'(height_o), 0);
    chk("R8 interlace", int'(interlace_o), 0);
    chk("R8 strobes", int'(upd_o) + int'(err_o), 0);
  endtask

  task automatic t_contig();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 0; vgap_max = 0;
    send_ctrl(16'd640, 16'd480, 4'h2, 0);
    chk_res("R3 contiguous", 640, 480, 2, 1, 0, u0, e0);
  endtask

  task automatic t_other_res();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 0; vgap_max = 0;
    send_ctrl(16'd1920, 16'd1080, 4'h1, 0);
    chk_res("R3 second size", 1920, 1080, 1, 1, 0, u0, e0);
  endtask

  task automatic t_ready_rand();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 1; vgap_max = 0;
    for (int p = 0; p < 4; p++) send_ctrl(16'd640, 16'd480, 4'h0, 0);
    chk_res("R5 random ready", 640, 480, 0, 4, 0, u0, e0);
  endtask

  task automatic t_pulse();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 2; vgap_max = 3;
    for (int p = 0; p < 3; p++) send_ctrl(16'd640, 16'd480, 4'h3, 0);
    chk_res("R5 R9 single ready pulses", 640, 480, 3, 3, 0, u0, e0);
  endtask

  task automatic t_valid_junk();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 1; vgap_max = 4;
    for (int p = 0; p < 3; p++) send_ctrl(16'd640, 16'd480, 4'h0, 0);
    chk_res("R1 junk between beats", 640, 480, 0, 3, 0, u0, e0);
  endtask

  task automatic t_short();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 1; vgap_max = 1;
    send_partial(4'hF, 5, 1'b1);
    settle();
    chk_res("R6 early end", 640, 480, 0, 0, 1, u0, e0);
    send_partial(4'hF, 0, 1'b1);
    settle();
    chk_res("R6 start with end", 640, 480, 0, 0, 2, u0, e0);
  endtask

  task automatic t_non_ctrl();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 1; vgap_max = 1;
    send_partial(4'h0, 12, 1'b1);
    settle();
    send_partial(4'h3, 10, 1'b1);
    settle();
    chk_res("R2 video and other types", 640, 480, 0, 0, 0, u0, e0);
  endtask

  task automatic t_extra();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 1; vgap_max = 2;
    send_ctrl(16'd1280, 16'd720, 4'h4, 3);
    chk_res("R7 trailing beats", 1280, 720, 4, 1, 0, u0, e0);
  endtask

  task automatic t_restart();
    int u0 = upd_seen, e0 = err_seen;
    rdy_mode = 0; vgap_max = 1;
    send_partial(4'hF, 5, 1'b0);
    send_ctrl(16'd800, 16'd600, 4'h5, 0);
    chk_res("R7 restart mid packet", 800, 600, 5, 1, 0, u0, e0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_contig();
    t_other_res();
    t_ready_rand();
    t_pulse();
    t_valid_junk();
    t_short();
    t_non_ctrl();
    t_extra();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule